// File: doc/BRIEF.md
# Line loss-of-signal monitor

This block watches a received serial bit stream and keeps one status bit that says whether the line is currently considered lost. Bits enter one at a time over a valid/ready input. The accepted bits are grouped into back-to-back detection windows, and the window length is a programmable number of bits. A window that holds no ones at all declares the line lost. A window that holds at least a programmable minimum number of ones declares it recovered. Any other window leaves the status as it was.

An alarm-simulation control forces the status high so that downstream alarm handling can be exercised without a real fault. When simulation is switched off, the status returns to whatever the real monitor has decided. Each rising edge of the status produces a one-clock interrupt pulse. The bit input never applies back-pressure: `bit_ready` is held high, and a bit counts in the cycle where `bit_valid` is high. Cycles without `bit_valid` are idle and advance nothing.

Top module: `los_monitor`

## Requirements
- R1: While `rst_n` is low and after its release, `los` is 1 and `los_irq` is 0, and the window and ones counts start from empty.
- R2: `bit_ready` is always 1, and a bit is accepted only in a cycle with `bit_valid` high. Cycles with `bit_valid` low change no count and no status.
- R3: Accepted bits form consecutive windows of `win_len` bits each. A `win_len` of 0 behaves as 1. The window verdict takes effect at the clock edge that accepts the window's last bit, and the status does not change in the middle of a window.
- R4: A window that holds zero ones sets the real loss state.
- R5: A window that holds at least `ones_min` ones clears the real loss state. A `ones_min` of 0 behaves as 1.
- R6: A window holding between 1 and `ones_min`-1 ones leaves the real loss state unchanged, whether it is set or clear.
- R7: One clock edge after `sim_en` is sampled high, `los` is 1, whatever the real state is.
- R8: `los_irq` is high for exactly one cycle, namely the first cycle in which `los` reads 1 after having been 0. There is no pulse when `los` is already 1.
- R9: When `sim_en` is sampled low, `los` equals the real loss state at that edge. This holds even when a window verdict falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A received bit is offered this cycle |
| bit_ready | output | 1 | Always 1; the monitor takes every offered bit |
| bit_data | input | 1 | Received bit value |
| win_len | input | WIN_W | Detection window length in bits (0 behaves as 1) |
| ones_min | input | CNT_W | Ones needed in a window to recover (0 behaves as 1) |
| sim_en | input | 1 | Alarm simulation: forces `los` high |
| los | output | 1 | Loss-of-signal status |
| los_irq | output | 1 | One-cycle pulse on each rising edge of `los` |

## Verification
Two functions can land on the same clock edge: a window verdict and a change of `sim_en`. The bench provokes this in two ways. It releases simulation in the same cycle that the last bit of a recovering window is accepted, and it expects `los` to fall at that edge. It also turns simulation on in the same cycle that an all-zero window closes. In that case the bench requires exactly one interrupt pulse, and it requires `los` to stay high after simulation is released, because the real alarm is still present.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int LOS_WIN_W_DFLT = 8;
  localparam int LOS_CNT_W_DFLT = 8;

  typedef enum logic [1:0] {
    VERDICT_HOLD  = 2'd0,
    VERDICT_SET   = 2'd1,
    VERDICT_CLEAR = 2'd2
  } los_verdict_e;
endpackage

// File: rtl/los_win_timer.sv
module los_win_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [WIN_W-1:0] pos_q;
  logic [WIN_W-1:0] last_pos;

  always_comb begin
    last_pos = (win_len == '0) ? '0 : win_len - WIN_W'(1);
    win_end  = step && (pos_q >= last_pos);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pos_q <= '0;
    else if (win_end) pos_q <= '0;
    else if (step)    pos_q <= pos_q + WIN_W'(1);
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q));
  p_window_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (pos_q == '0));
endmodule

// File: rtl/los_ones_counter.sv
module los_ones_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  input  logic             win_end,
  output logic [CNT_W-1:0] ones_total
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (step && bit_in && (cnt_q != CNT_MAX)) ones_total = cnt_q + CNT_W'(1);
    else                                      ones_total = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (win_end) cnt_q <= '0;
    else if (step)    cnt_q <= ones_total;
  end

  p_count_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt_q == '0));
  p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
endmodule

// File: rtl/los_state.sv
module los_state
  import los_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic [CNT_W-1:0] ones_total,
  input  logic [CNT_W-1:0] ones_min,
  input  logic             sim_en,
  output logic             los,
  output logic             los_irq
);
  los_verdict_e     verdict;
  logic [CNT_W-1:0] need;
  logic             real_q, real_nxt, los_q, los_nxt, irq_q;

  always_comb begin
    need = (ones_min == '0) ? CNT_W'(1) : ones_min;
    if (!win_end)                verdict = VERDICT_HOLD;
    else if (ones_total == '0)   verdict = VERDICT_SET;
    else if (ones_total >= need) verdict = VERDICT_CLEAR;
    else                         verdict = VERDICT_HOLD;
    case (verdict)
      VERDICT_SET:   real_nxt = 1'b1;
      VERDICT_CLEAR: real_nxt = 1'b0;
      default:       real_nxt = real_q;
    endcase
    los_nxt = sim_en | real_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      real_q <= 1'b1;
      los_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      real_q <= real_nxt;
      los_q  <= los_nxt;
      irq_q  <= los_nxt & ~los_q;
    end
  end

  assign los     = los_q;
  assign los_irq = irq_q;

  p_zero_window_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && ones_total == '0) |=> real_q);
  p_enough_ones_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && ones_total != '0 && ones_total >= need) |=> !real_q);
  p_sim_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sim_en |=> los);
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    los_irq |=> !los_irq);
  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    los_irq |-> (los && !$past(los)));
  p_release_follows_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sim_en |=> (los == real_q));
endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int WIN_W = LOS_WIN_W_DFLT,
  parameter int CNT_W = LOS_CNT_W_DFLT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_data,
  input  logic [WIN_W-1:0] win_len,
  input  logic [CNT_W-1:0] ones_min,
  input  logic             sim_en,
  output logic             los,
  output logic             los_irq
);
  logic             step;
  logic             win_end;
  logic [CNT_W-1:0] ones_total;

  assign bit_ready = 1'b1;
  assign step      = bit_valid & bit_ready;

  los_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .step(step), .win_len(win_len), .win_end(win_end)
  );

  los_ones_counter #(.CNT_W(CNT_W)) u_ones (
    .clk(clk), .rst_n(rst_n), .step(step), .bit_in(bit_data),
    .win_end(win_end), .ones_total(ones_total)
  );

  los_state #(.CNT_W(CNT_W)) u_state (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .ones_total(ones_total),
    .ones_min(ones_min), .sim_en(sim_en), .los(los), .los_irq(los_irq)
  );

  p_never_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> bit_ready);
endmodule

// File: tb/los_monitor_tb_top.sv
module los_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic [WIN_W-1:0] win_len = 8'd8;
  logic [CNT_W-1:0] ones_min = 8'd3;
  logic sim_en = 1'b0;
  logic bit_ready, los, los_irq;
  int errors = 0;
  int checks = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_monitor #(.WIN_W(WIN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .win_len(win_len), .ones_min(ones_min),
    .sim_en(sim_en), .los(los), .los_irq(los_irq)
  );

  always @(posedge clk) if (rst_n && los_irq) irq_seen <= irq_seen + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1;
    bit_data  = b;
    @(posedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] bits, input int n);
    for (int i = 0; i < n; i++) send_bit(bits[i]);
  endtask

  task automatic t_reset;
    chk("R1 los after reset", los, 1);
    chk("R1 irq after reset", los_irq, 0);
    chk("R2 ready", bit_ready, 1);
  endtask

  task automatic t_hold_lost;
    send_word(8'b0000_0101, 8);
    chk("R6 two ones keep loss", los, 1);
  endtask

  task automatic t_recover;
    send_word(8'b0000_0011, 7);
    chk("R3 no change mid-window", los, 1);
    send_bit(1'b1);
    chk("R5 three ones clear", los, 0);
    chk("R8 no irq on fall", irq_seen, 0);
  endtask

  task automatic t_hold_clear;
    send_word(8'b0000_0001, 8);
    chk("R6 one one keeps clear", los, 0);
  endtask

  task automatic t_idle_then_set;
    send_word(8'h00, 7);
    repeat (20) @(negedge clk);
    chk("R2 idle cycles ignored", los, 0);
    send_bit(1'b0);
    chk("R4 zero window sets", los, 1);
    chk("R8 irq high first cycle", los_irq, 1);
    @(negedge clk);
    chk("R8 irq one cycle", los_irq, 0);
    chk("R8 one pulse", irq_seen, 1);
  endtask

  task automatic t_sim;
    send_word(8'hFF, 8);
    chk("R5 recover before sim", los, 0);
    sim_en = 1'b1;
    @(negedge clk);
    chk("R7 sim forces los", los, 1);
    chk("R8 irq on sim rise", los_irq, 1);
    send_word(8'hFF, 8);
    chk("R7 sim holds over ones", los, 1);
    sim_en = 1'b0;
    @(negedge clk);
    chk("R9 release to clear", los, 0);
    chk("R8 pulse count", irq_seen, 2);
  endtask

  task automatic t_sim_over_real;
    send_word(8'h00, 8);
    chk("R4 set again", los, 1);
    sim_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no irq when already high", irq_seen, 3);
    sim_en = 1'b0;
    @(negedge clk);
    chk("R9 release keeps real loss", los, 1);
  endtask

  task automatic t_coincide_clear;
    sim_en = 1'b1;
    send_word(8'hFF, 7);
    chk("R7 sim during window", los, 1);
    sim_en = 1'b0;
    send_bit(1'b1);
    chk("R9 release with recovery same cycle", los, 0);
  endtask

  task automatic t_coincide_set;
    send_word(8'h00, 7);
    chk("R3 still clear mid-window", los, 0);
    sim_en = 1'b1;
    send_bit(1'b0);
    chk("R7 los high", los, 1);
    repeat (2) @(negedge clk);
    chk("R8 single irq for coincident set", irq_seen, 4);
    sim_en = 1'b0;
    @(negedge clk);
    chk("R9 real loss remains", los, 1);
  endtask

  task automatic t_window_len;
    win_len  = 8'd4;
    ones_min = 8'd0;
    send_word(8'b0000_0001, 4);
    chk("R5 min zero acts as one", los, 0);
    send_word(8'h00, 3);
    chk("R3 short window mid", los, 0);
    send_bit(1'b0);
    chk("R3 four-bit window sets", los, 1);
    win_len = 8'd0;
    send_bit(1'b1);
    chk("R3 length zero acts as one clear", los, 0);
    send_bit(1'b0);
    chk("R3 length zero acts as one set", los, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 los during reset", los, 1);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_lost();
    t_recover();
    t_hold_clear();
    t_idle_then_set();
    t_sim();
    t_sim_over_real();
    t_coincide_clear();
    t_coincide_set();
    t_window_len();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule